// File: doc/BRIEF.md
# Phase-Aligned Clock Divider with Release Hold-Off

This block takes a fast clock and produces a slower clock at one half, one quarter or one eighth of its rate. The ratio is chosen by a 2-bit select input. The divided output is held low after reset until a release input is seen high on a rising edge of the fast clock. That sampling edge acts as the phase reference: the first divided rising edge follows it by a fixed number of fast-clock cycles. Every divider released on the same edge therefore lands in the same phase against the fast clock.

Reset is asserted asynchronously. It is removed through a two-stage synchronizer on the fast clock, so the release point can be predicted to the cycle. A lock flag tells downstream logic that the divided clock has produced its first rising edge.

Top module: `clkdiv_aligned`

## Requirements
- R1: The select input `div_sel` picks the ratio N. 2'b00 gives N=2, 2'b01 gives N=4, and both 2'b10 and 2'b11 give N=8.
- R2: After reset has been removed and before release has been sampled high, `clk_div_o` and `locked_o` stay low.
- R3: Driving `rst_n` low forces `clk_div_o` and `locked_o` low at once, without waiting for a clock edge. After `rst_n` returns high, the internal reset ends on the second fast-clock rising edge. Release is ignored until that edge, so with `release_i` already high and N=2, `clk_div_o` first rises on the fourth rising edge after `rst_n` goes high.
- R4: Once running, `clk_div_o` is high for exactly N/2 fast-clock cycles and low for exactly N/2 cycles, giving a period of N.
- R5: `div_sel` is captured on the release edge. Later changes to it have no effect until the next reset and release.
- R6: If release is first sampled high on fast-clock edge E0, `clk_div_o` first goes high on edge E0+N/2.
- R7: `locked_o` rises on the same edge as the first rising edge of `clk_div_o`. It stays high until reset.
- R8: Release is sticky. Driving `release_i` low after it has been sampled does not stop or disturb the divided clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, removed through a synchronizer |
| release_i | input | 1 | Release request, sampled on clk_fast rising edges |
| div_sel | input | 2 | Ratio select (00:/2, 01:/4, 1x:/8) |
| clk_div_o | output | 1 | Divided clock, 50% duty |
| locked_o | output | 1 | High from the first divided rising edge until reset |

## Verification
Two events can fall on the same fast-clock cycle: the release edge that arms the divider and the end of the reset synchronizer. The bench provokes this by holding `release_i` high for the whole reset and then letting go of `rst_n`. It then checks that the divided clock stays low for exactly three samples and rises on the fourth. The first divided rising edge and the setting of the lock flag also share an edge. For every ratio, the bench checks that the lock flag is low in the sample just before the rise and high in the sample where the rise appears.

// File: rtl/clkdiv_pkg.sv
// Shared constants, the half-period type and the ratio decode for the divider.
// Assumes the largest ratio is 8, so the half period never exceeds 4.
package clkdiv_pkg;
    localparam int unsigned HALF_MAX = 4;
    localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);

    typedef logic [HALF_W-1:0] half_t;

    // Maps the ratio select onto a half period in fast-clock cycles.
    function automatic half_t sel_to_half(input logic [1:0] sel);
        case (sel)
            2'b00:   return half_t'(1);
            2'b01:   return half_t'(2);
            default: return half_t'(HALF_MAX);
        endcase
    endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
// Reset synchronizer: asserts asynchronously and releases after STAGES edges.
// Assumes STAGES >= 2.
module clkdiv_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain_q;

    // Shift ones through the chain once the asynchronous reset is removed.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_arm.sv
// Release latch: arms the divider on the first sampled release edge and
// freezes the ratio chosen at that edge. Release is ignored once armed.
module clkdiv_arm
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       release_i,
    input  logic [1:0] sel,
    output logic       run_o,
    output half_t      half_o
);
    // Capture the run state and the ratio on the release edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o  <= 1'b0;
            half_o <= half_t'(1);
        end else if (!run_o && release_i) begin
            run_o  <= 1'b1;
            half_o <= sel_to_half(sel);
        end
    end
endmodule

// File: rtl/clkdiv_toggle.sv
// Half-period counter and output toggle. The counter holds at zero while not
// running. The output flips when the count reaches half-1.
module clkdiv_toggle
    import clkdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  half_t half,
    output logic  div_o,
    output logic  rise_o
);
    half_t cnt_q;
    logic  wrap;

    // Detect the end of a half period.
    always_comb wrap = run && (cnt_q == half - half_t'(1));

    // Advance the counter and flip the output at each wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_o <= 1'b0;
        end else if (run) begin
            if (wrap) begin
                cnt_q <= '0;
                div_o <= ~div_o;
            end else begin
                cnt_q <= cnt_q + half_t'(1);
            end
        end
    end

    // Flag a wrap that will take the output from low to high.
    always_comb rise_o = wrap && !div_o;
endmodule

// File: rtl/clkdiv_lock.sv
// Lock flag: sets on the first upward toggle and holds until reset.
module clkdiv_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic locked_o
);
    // Sticky set on the first rising toggle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    locked_o <= 1'b0;
        else if (rise) locked_o <= 1'b1;
    end
endmodule

// File: rtl/clkdiv_aligned.sv
// Top of the phase-aligned divider. Synchronizes reset, arms on release,
// counts half periods and reports lock. Every flop is clocked by clk_fast.
module clkdiv_aligned
    import clkdiv_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_fast,
    input  logic       rst_n,
    input  logic       release_i,
    input  logic [1:0] div_sel,
    output logic       clk_div_o,
    output logic       locked_o
);
    logic  rst_sync_n;
    logic  run_q;
    half_t half_q;
    logic  rise_evt;

    clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_fast),
        .arst_n (rst_n),
        .srst_n (rst_sync_n)
    );

    clkdiv_arm u_arm (
        .clk       (clk_fast),
        .rst_n     (rst_sync_n),
        .release_i (release_i),
        .sel       (div_sel),
        .run_o     (run_q),
        .half_o    (half_q)
    );

    clkdiv_toggle u_tog (
        .clk    (clk_fast),
        .rst_n  (rst_sync_n),
        .run    (run_q),
        .half   (half_q),
        .div_o  (clk_div_o),
        .rise_o (rise_evt)
    );

    clkdiv_lock u_lock (
        .clk      (clk_fast),
        .rst_n    (rst_sync_n),
        .rise     (rise_evt),
        .locked_o (locked_o)
    );
endmodule

// File: rtl/clkdiv_aligned_chk.sv
// Checker for clkdiv_aligned. It measures each half period with its own
// counter and relates the outputs to the reset, run and ratio state.
module clkdiv_aligned_chk
    import clkdiv_pkg::*;
(
    input logic  clk,
    input logic  arst_n,
    input logic  rst_s_n,
    input logic  run,
    input half_t half,
    input logic  div,
    input logic  locked
);
    int unsigned gap_q;
    logic        last_q;

    // Count edges since the last observed change of the divided clock.
    always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
            gap_q  <= 0;
            last_q <= 1'b0;
        end else if (run) begin
            gap_q  <= (div != last_q) ? 1 : gap_q + 1;
            last_q <= div;
        end
    end

    p_reset_low_r3: assert property (@(posedge clk)
        !arst_n |-> (!div && !locked));

    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
        !run |-> (!div && !locked));

    // Covers R6 as well: the first change is measured from the release edge.
    p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
        (run && div != last_q) |-> (gap_q == 32'(half)));

    p_ratio_frozen_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
        (run && $past(run)) |-> $stable(half));

    p_lock_with_rise_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
        $rose(locked) |-> $rose(div));

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
        locked |=> locked);
endmodule

bind clkdiv_aligned clkdiv_aligned_chk u_chk (
    .clk     (clk_fast),
    .arst_n  (rst_n),
    .rst_s_n (rst_sync_n),
    .run     (run_q),
    .half    (half_q),
    .div     (clk_div_o),
    .locked  (locked_o)
);

// File: tb/sim_clkdiv_aligned.sv
`timescale 1ns/1ps
module sim_clkdiv_aligned;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       rel = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       cdiv;
    logic       lck;
    int         checks = 0;
    int         fails = 0;
    logic       done = 1'b0;

    localparam int NV = 4;
    localparam logic [1:0] SEL_T [NV] = '{2'b00, 2'b01, 2'b10, 2'b11};
    localparam int         RAT_T [NV] = '{2, 4, 8, 8};

    always #2.5 clk = ~clk;

    clkdiv_aligned u0 (
        .clk_fast (clk),
        .rst_n    (rst_n),
        .release_i(rel),
        .div_sel  (sel),
        .clk_div_o(cdiv),
        .locked_o (lck)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset, then wait with release low; the outputs must stay low throughout.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rel   = 1'b0;
        #1;
        chk(!cdiv && !lck, "R3 async low", int'(cdiv), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!cdiv && !lck, "R2 idle low", int'(cdiv), 0);
    endtask

    // Release, then measure the first-rise delay, lock, high and low times.
    task automatic run_measure(input int n, input string tag, input logic change_sel);
        int k;
        int hi;
        int lo;
        logic prev_lck;
        rel = 1'b1;
        k = 0;
        prev_lck = 1'b0;
        @(negedge clk);
        rel = 1'b0;  // R8: drop release at once
        while (!cdiv && k < 64) begin
            prev_lck = lck;
            k++;
            @(negedge clk);
        end
        chk(k == n / 2, {tag, " R6 first rise"}, k, n / 2);
        chk(!prev_lck && lck, {tag, " R7 lock with rise"}, int'(lck), 1);
        if (change_sel) sel = 2'b10;  // R5: ignored while running
        hi = 0;
        while (cdiv && hi < 64) begin hi++; @(negedge clk); end
        lo = 0;
        while (!cdiv && lo < 64) begin lo++; @(negedge clk); end
        chk(hi == n / 2, {tag, " R4 high time"}, hi, n / 2);
        chk(hi + lo == n, {tag, " R4 period R1 R8"}, hi + lo, n);
        chk(lck, {tag, " R7 lock held"}, int'(lck), 1);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #2;
        chk(!cdiv && !lck, "R3 reset state", int'(cdiv), 0);
        for (int i = 0; i < NV; i++) begin
            do_reset();
            sel = SEL_T[i];
            run_measure(RAT_T[i], $sformatf("R1 sel=%0d", SEL_T[i]), 1'b0);
        end
        // R5: select changed mid-run keeps divide-by-2.
        do_reset();
        sel = 2'b00;
        run_measure(2, "R5 sel change", 1'b1);
        // R3: reset mid-run drops outputs without a clock edge.
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk(!cdiv && !lck, "R3 mid-run reset", int'(cdiv) + int'(lck), 0);
        // R3: release held through reset; rise lands on the 4th edge.
        sel = 2'b00;
        rel = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 1; e <= 3; e++) begin
            @(negedge clk);
            chk(!cdiv, $sformatf("R3 sync hold edge %0d", e), int'(cdiv), 0);
        end
        @(negedge clk);
        chk(cdiv && lck, "R3 rise on 4th edge", int'(cdiv), 1);
        rel = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule